// File: doc/BRIEF.md
# Per-Lane Buffer Address Generator

This block turns one vector buffer access into a memory address for each lane. It takes the fields of a buffer resource descriptor (base, stride, record count, layout select, element size, index stride and a thread-ID enable), together with a per-lane index and offset, a scalar offset, an immediate offset and an execution mask. It returns the address vector, a per-lane out-of-range mask and the active-lane mask. Downstream logic forces load data to zero and drops the write for each lane whose out-of-range bit is set.

Two layouts are supported. The linear layout places record `index` at `stride * index`. The swizzled layout interleaves elements of consecutive indices within groups of `index stride` records. All divisions are by powers of two, so they reduce to shifts and masks. Operations enter through a valid/ready handshake, one at a time. The result appears a fixed two cycles after acceptance.

Top module: `buf_addr_gen`

## Requirements
- R1: `in_ready` is high when no operation is in flight. It drops in the cycle after an operation is accepted and stays low until that operation's result has been presented. `out_valid` is high for exactly one cycle, two clock edges after the accepting edge.
- R2: The lane index is `lane_idx` when `idx_en` is 1, otherwise 0. Lane number `i` (0-based) is added to it when `d_tid_en` is 1. The sum wraps at 32 bits.
- R3: The lane offset is `lane_off` when `off_en` is 1, otherwise 0. `imm_off` is always added to it. The sum wraps at 32 bits.
- R4: When `d_swz` is 0, the address is `d_base + s_off + offset + d_stride * index`.
- R5: When `d_swz` is 1, the element size E is 2, 4, 8 or 16 bytes for `d_esz` codes 0 to 3, and the group size G is 8, 16, 32 or 64 for `d_istr` codes 0 to 3. The address is `d_base + s_off + ((index/G * d_stride + offset/E * E) * G + (index%G) * E + offset%E)`.
- R6: When `d_stride` is nonzero, an active lane is flagged out of range when its index is greater than or equal to `d_nrec`.
- R7: When `d_stride` is zero, an active lane is flagged out of range when its offset is greater than or equal to `d_nrec`.
- R8: A lane whose `exec_mask` bit is 0 is never flagged out of range and reports address 0. `out_active` equals the accepted `exec_mask`.
- R9: Addresses wrap modulo 2^48.
- R10: While reset is asserted, and right after it, `out_valid` is 0, `out_oob` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| d_base | input | 48 | Descriptor base address |
| d_stride | input | 14 | Record stride in bytes |
| d_nrec | input | 32 | Number of records (range limit) |
| d_swz | input | 1 | 1 selects the swizzled layout |
| d_tid_en | input | 1 | Add the lane number to the index |
| d_esz | input | 2 | Element size code |
| d_istr | input | 2 | Index stride code |
| idx_en | input | 1 | Use the per-lane index |
| off_en | input | 1 | Use the per-lane offset |
| imm_off | input | 12 | Immediate offset |
| s_off | input | 32 | Scalar offset |
| exec_mask | input | LANES | Execution mask |
| lane_idx | input | LANES*32 | Per-lane index, lane 0 in the low bits |
| lane_off | input | LANES*32 | Per-lane offset, lane 0 in the low bits |
| out_valid | output | 1 | Result valid |
| out_addr | output | LANES*48 | Per-lane address, lane 0 in the low bits |
| out_oob | output | LANES | Per-lane out-of-range flag |
| out_active | output | LANES | Active-lane mask |

## Verification
The hardest case to reach is a swizzled access in which the lanes straddle an index-stride group boundary while their offsets cross element boundaries. Only then are all four parts of the swizzled sum nonzero and different from lane to lane. The stimulus table therefore builds each lane's index and offset as a base plus a per-lane step, chosen so that consecutive lanes fall on both sides of a group boundary and of an element boundary. Other rows combine masked lanes with ranges that would otherwise fail, and a base just below 2^48 to force the address to wrap.

// File: rtl/buf_addr_gen.sv
module buf_addr_gen #(
  parameter int LANES = 4,
  parameter int AW    = 48,
  parameter int IW    = 32,
  parameter int SW    = 14,
  parameter int IMMW  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [AW-1:0]       d_base,
  input  logic [SW-1:0]       d_stride,
  input  logic [IW-1:0]       d_nrec,
  input  logic                d_swz,
  input  logic                d_tid_en,
  input  logic [1:0]          d_esz,
  input  logic [1:0]          d_istr,
  input  logic                idx_en,
  input  logic                off_en,
  input  logic [IMMW-1:0]     imm_off,
  input  logic [IW-1:0]       s_off,
  input  logic [LANES-1:0]    exec_mask,
  input  logic [LANES*IW-1:0] lane_idx,
  input  logic [LANES*IW-1:0] lane_off,
  output logic                out_valid,
  output logic [LANES*AW-1:0] out_addr,
  output logic [LANES-1:0]    out_oob,
  output logic [LANES-1:0]    out_active
);

  logic             s1_v;
  logic [AW-1:0]    base_q;
  logic [SW-1:0]    stride_q;
  logic [IW-1:0]    nrec_q, soff_q;
  logic             swz_q;
  logic [1:0]       esz_q, istr_q;
  logic [LANES-1:0] exec_q;
  logic [IW-1:0]    idx_q [LANES];
  logic [IW-1:0]    off_q [LANES];

  wire accept = in_valid && in_ready;
  assign in_ready = !s1_v && !out_valid;

  wire [2:0] ish = {1'b0, istr_q} + 3'd3;
  wire [2:0] esh = {1'b0, esz_q} + 3'd1;
  wire [AW-1:0] base_sum = base_q + AW'(soff_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_v      <= accept;
      out_valid <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      base_q   <= d_base;
      stride_q <= d_stride;
      nrec_q   <= d_nrec;
      soff_q   <= s_off;
      swz_q    <= d_swz;
      esz_q    <= d_esz;
      istr_q   <= d_istr;
      exec_q   <= exec_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_active <= '0;
    else if (s1_v) out_active <= exec_q;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [IW-1:0] idx_in = (idx_en ? lane_idx[i*IW +: IW] : '0) + (d_tid_en ? IW'(i) : '0);
    wire [IW-1:0] off_in = (off_en ? lane_off[i*IW +: IW] : '0) + IW'(imm_off);

    always_ff @(posedge clk) begin
      if (accept) begin
        idx_q[i] <= idx_in;
        off_q[i] <= off_in;
      end
    end

    wire [IW-1:0] ix = idx_q[i];
    wire [IW-1:0] ox = off_q[i];
    wire [AW-1:0] ihi = AW'(ix >> ish);
    wire [AW-1:0] ilo = AW'(ix & ((IW'(1) << ish) - IW'(1)));
    wire [AW-1:0] ohi = AW'(ox >> esh);
    wire [AW-1:0] olo = AW'(ox & ((IW'(1) << esh) - IW'(1)));
    wire [AW-1:0] grp = (ihi * AW'(stride_q) + (ohi << esh)) << ish;
    wire [AW-1:0] swz_addr = base_sum + grp + (ilo << esh) + olo;
    wire [AW-1:0] lin_addr = base_sum + AW'(ox) + AW'(ix) * AW'(stride_q);
    wire          beyond = (stride_q != '0) ? (ix >= nrec_q) : (ox >= nrec_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_oob[i]            <= 1'b0;
        out_addr[i*AW +: AW]  <= '0;
      end else if (s1_v) begin
        out_oob[i]            <= exec_q[i] && beyond;
        out_addr[i*AW +: AW]  <= exec_q[i] ? (swz_q ? swz_addr : lin_addr) : '0;
      end
    end
  end

endmodule

// File: rtl/buf_addr_gen_checker.sv
module buf_addr_gen_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] exec_mask,
  input logic             out_valid,
  input logic [LANES-1:0] out_oob,
  input logic [LANES-1:0] out_active
);

  assert_result_two_later_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 out_valid);

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_inactive_not_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_oob & ~out_active) == '0));

  assert_active_from_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 2) && out_valid) |-> (out_active == $past(exec_mask, 2)));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready && out_oob == '0));

endmodule

bind buf_addr_gen buf_addr_gen_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .exec_mask(exec_mask), .out_valid(out_valid), .out_oob(out_oob),
  .out_active(out_active)
);

// File: tb/buf_addr_gen_bench.sv
module buf_addr_gen_bench;
  localparam int L = 4;
  localparam int NV = 8;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic in_valid = 0, in_ready;
  logic [47:0] d_base = 0;
  logic [13:0] d_stride = 0;
  logic [31:0] d_nrec = 0, s_off = 0;
  logic d_swz = 0, d_tid_en = 0, idx_en = 0, off_en = 0;
  logic [1:0] d_esz = 0, d_istr = 0;
  logic [11:0] imm_off = 0;
  logic [L-1:0] exec_mask = 0;
  logic [L*32-1:0] lane_idx = 0, lane_off = 0;
  logic out_valid;
  logic [L*48-1:0] out_addr;
  logic [L-1:0] out_oob, out_active;

  buf_addr_gen u_buf_addr_gen (.*);

  // row: swz esz istr stride nrec tid idxen offen imm base soff exec ib is ob os
  localparam logic        V_SWZ [NV] = '{0,0,0,1,1,1,0,0};
  localparam logic [1:0]  V_ESZ [NV] = '{0,0,0,1,3,0,0,0};
  localparam logic [1:0]  V_IST [NV] = '{0,0,0,0,3,1,0,0};
  localparam logic [13:0] V_STR [NV] = '{16,0,8,32,100,0,0,5};
  localparam logic [31:0] V_NRC [NV] = '{100,'h30,3,1000,1000,40,'hFFFFFFFF,0};
  localparam logic        V_TID [NV] = '{0,0,1,0,1,0,0,0};
  localparam logic        V_IEN [NV] = '{1,0,1,1,1,1,0,0};
  localparam logic        V_OEN [NV] = '{1,1,0,1,1,1,1,1};
  localparam logic [11:0] V_IMM [NV] = '{4,0,0,0,8,2,0,0};
  localparam logic [47:0] V_BAS [NV] = '{'h1000,'h5000,'h800,'h2000,'h3_0000,'h40,'hFFFF_FFFF_FF00,'h10};
  localparam logic [31:0] V_SOF [NV] = '{'h100,0,'h20,'h10,'h4,0,'h80,0};
  localparam logic [3:0]  V_EXE [NV] = '{4'hF,4'hF,4'b1011,4'hF,4'hF,4'hF,4'hF,4'h0};
  localparam logic [31:0] V_IB  [NV] = '{3,0,0,6,60,15,0,0};
  localparam logic [31:0] V_IS  [NV] = '{1,0,0,1,3,1,0,0};
  localparam logic [31:0] V_OB  [NV] = '{0,'h10,0,5,17,30,'h40,7};
  localparam logic [31:0] V_OS  [NV] = '{8,'h10,0,3,33,5,'h40,1};

  int total = 0, bad = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned m_idx(int v, int l);
    return longint'(32'((V_IEN[v] ? V_IB[v] + 32'(l) * V_IS[v] : 32'd0) + (V_TID[v] ? 32'(l) : 32'd0)));
  endfunction
  function automatic longint unsigned m_off(int v, int l);
    return longint'(32'((V_OEN[v] ? V_OB[v] + 32'(l) * V_OS[v] : 32'd0) + 32'(V_IMM[v])));
  endfunction
  function automatic longint unsigned m_addr(int v, int l);
    longint unsigned ix = m_idx(v, l), of = m_off(v, l);
    longint unsigned st = longint'(V_STR[v]);
    longint unsigned e = 2 << V_ESZ[v], g = 8 << V_IST[v];
    longint unsigned a;
    if (!V_EXE[v][l]) return 0;
    if (V_SWZ[v]) a = V_BAS[v] + V_SOF[v] + ((ix / g) * st + (of / e) * e) * g + (ix % g) * e + of % e;
    else a = V_BAS[v] + V_SOF[v] + of + st * ix;
    return a & 64'hFFFF_FFFF_FFFF;
  endfunction
  function automatic logic m_oob(int v, int l);
    if (!V_EXE[v][l]) return 0;
    return (V_STR[v] != 0) ? (m_idx(v, l) >= V_NRC[v]) : (m_off(v, l) >= V_NRC[v]);
  endfunction

  task automatic load(input int v);
    d_swz = V_SWZ[v]; d_esz = V_ESZ[v]; d_istr = V_IST[v]; d_stride = V_STR[v];
    d_nrec = V_NRC[v]; d_tid_en = V_TID[v]; idx_en = V_IEN[v]; off_en = V_OEN[v];
    imm_off = V_IMM[v]; d_base = V_BAS[v]; s_off = V_SOF[v]; exec_mask = V_EXE[v];
    for (int l = 0; l < L; l++) begin
      lane_idx[l*32 +: 32] = V_IB[v] + 32'(l) * V_IS[v];
      lane_off[l*32 +: 32] = V_OB[v] + 32'(l) * V_OS[v];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "out_valid in reset", out_valid, 0);
    check("R10", "in_ready in reset", in_ready, 1);
    check("R10", "out_oob in reset", out_oob, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] eo;
      load(v);
      check("R1", "ready before offer", in_ready, 1);
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      check("R1", "busy after accept", in_ready, 0);
      check("R1", "no early result", out_valid, 0);
      @(negedge clk);
      check("R1", "result valid", out_valid, 1);
      for (int l = 0; l < L; l++)
        check(V_SWZ[v] ? "R5" : "R4", $sformatf("row %0d lane %0d addr", v, l),
              out_addr[l*48 +: 48], m_addr(v, l));
      for (int l = 0; l < L; l++) eo[l] = m_oob(v, l);
      check(V_STR[v] != 0 ? "R6" : "R7", $sformatf("row %0d oob", v), out_oob, eo);
      check("R8", $sformatf("row %0d active", v), out_active, V_EXE[v]);
      @(negedge clk);
      check("R1", "single pulse", out_valid, 0);
    end

    // R2 R3: lane 2 of row 2 is inactive and lane 3 exceeds 3 records; row 7 masks all lanes (R8)
    // R9: row 6 wraps; check lane 3 explicitly
    check("R9", "wrap lane3 expected small", m_addr(6, 3) < 48'h1000, 1);

    // R1: continuous offer yields one result every three cycles
    begin
      int pulses = 0;
      load(0);
      in_valid = 1;
      for (int c = 0; c < 9; c++) begin
        @(negedge clk);
        if (out_valid) pulses++;
      end
      in_valid = 0;
      check("R1", "pulses under continuous offer", pulses, 3);
    end

    // R10: reset mid-flight
    load(1);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check("R10", "flight cleared by reset", out_valid, 0);
    check("R10", "ready after reset", in_ready, 1);
    @(negedge clk);
    check("R10", "no stale result", out_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule